// File: doc/BRIEF.md
# Host Asynchronous Packet Queue Interface

This block sits between a host register port and the asynchronous side of a serial-bus link controller. It holds four quadlet queues. Two are receive queues, one for request packets and one for response packets. The link pushes each received quadlet into one of them according to the packet type, and the host drains them one quadlet per register read. The other two are transmit queues, again one for requests and one for responses.

The host fills a transmit queue by writing every quadlet except the final one to a "continue" register. It then writes the final quadlet to a "finish" register. The write to the finish register marks the packet complete and raises the queue's count of packets ready to send. The transmitter can start on the packet without any other host action.

The queues carry no length field. Packet boundaries come from a one-bit end tag stored beside every quadlet. The end tag drives a live "head is final" status bit on the receive side, and it tells the transmit side where each packet stops. A status register reports queue occupancy and two sticky error flags. One flag is for a read from an empty receive queue and the other is for a write into a full transmit queue. The host clears each flag by writing 1 to its bit.

Top module: `host_async_queue`

## Requirements
- R1: After reset, the status register (address 6) reads 0, and both transmit ready counts are 0.
- R2: A quadlet pushed with `rx_resp`=0 goes to the request receive queue, which is read at address 0. A quadlet pushed with `rx_resp`=1 goes to the response receive queue, which is read at address 1.
- R3: Status bit 0 (request queue) and status bit 2 (response queue) are 1 exactly while the matching receive queue holds at least one quadlet.
- R4: Each host read of address 0 or 1 returns the head quadlet of that queue on `hst_rdata` in the cycle after the read and removes that quadlet. Quadlets leave in arrival order.
- R5: Status bit 1 (request) and status bit 3 (response) are 1 when the head quadlet of that receive queue was pushed with `rx_last`=1.
- R6: A read of address 0 or 1 while that queue is empty returns 0, removes nothing and sets the read error flag in status bit 4.
- R7: A host write to address 2 (request) or address 4 (response) appends a quadlet with end tag 0. A write to address 3 (request) or address 5 (response) appends a quadlet with end tag 1. The head quadlet and its end tag appear on `tx_*_data` and `tx_*_end`.
- R8: Each accepted finish-register write raises that queue's `tx_*_pkts` by 1. Popping an entry whose end tag is 1 lowers it by 1. A pop is ignored while the count is 0.
- R9: The request and response transmit queues, and their ready counts, are fully independent.
- R10: A write into a transmit queue that already holds DEPTH quadlets is dropped. The dropped write leaves the queue contents and the ready count unchanged and sets the write error flag in status bit 5.
- R11: Writing address 6 clears status bits 4 and 5 where the write data has a 1 and leaves them where it has a 0. When a new error occurs in the same cycle, it keeps the flag set.
- R12: Reading address 6 removes nothing from any queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_rd | input | 1 | Host read strobe, one cycle per access |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_addr | input | 3 | Host register address |
| hst_wdata | input | DW | Host write data |
| hst_rdata | output | DW | Host read data, registered |
| rx_push | input | 1 | Link pushes a received quadlet |
| rx_resp | input | 1 | 1 when the pushed quadlet belongs to a response packet |
| rx_last | input | 1 | 1 when the pushed quadlet ends its packet |
| rx_data | input | DW | Received quadlet |
| rx_req_full | output | 1 | Request receive queue is full |
| rx_rsp_full | output | 1 | Response receive queue is full |
| tx_req_pop | input | 1 | Transmitter takes the head request quadlet |
| tx_req_data | output | DW | Head request quadlet |
| tx_req_end | output | 1 | End tag of the head request quadlet |
| tx_req_pkts | output | AW+1 | Complete request packets ready to send |
| tx_rsp_pop | input | 1 | Transmitter takes the head response quadlet |
| tx_rsp_data | output | DW | Head response quadlet |
| tx_rsp_end | output | 1 | End tag of the head response quadlet |
| tx_rsp_pkts | output | AW+1 | Complete response packets ready to send |

## Verification
The assertions assume a host that raises at most one of `hst_rd` and `hst_wr` in a cycle. They also assume the link never pushes into a receive queue that reports full. The bench drives each host access as a single-cycle strobe set between clock edges and pushes far fewer quadlets than the receive depth. It pops a transmit queue only while its ready count is nonzero, except where a test aims to show that an early pop is ignored.

// File: rtl/host_async_queue.sv
module host_async_queue #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_rd,
  input  logic              hst_wr,
  input  logic [2:0]        hst_addr,
  input  logic [DW-1:0]     hst_wdata,
  output logic [DW-1:0]     hst_rdata,
  input  logic              rx_push,
  input  logic              rx_resp,
  input  logic              rx_last,
  input  logic [DW-1:0]     rx_data,
  output logic              rx_req_full,
  output logic              rx_rsp_full,
  input  logic              tx_req_pop,
  output logic [DW-1:0]     tx_req_data,
  output logic              tx_req_end,
  output logic [$clog2(DEPTH):0] tx_req_pkts,
  input  logic              tx_rsp_pop,
  output logic [DW-1:0]     tx_rsp_data,
  output logic              tx_rsp_end,
  output logic [$clog2(DEPTH):0] tx_rsp_pkts
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);

  logic [3:0]          push, pop, full, empty;
  logic [3:0][DW:0]    din, head;
  logic [3:0][AW:0]    cnt;
  logic [1:0][AW:0]    pkts;
  logic                rd_err, wr_err;

  wire rd_q0  = hst_rd && hst_addr == 3'd0;
  wire rd_q1  = hst_rd && hst_addr == 3'd1;
  wire wr_rq  = hst_wr && (hst_addr == 3'd2 || hst_addr == 3'd3);
  wire wr_rp  = hst_wr && (hst_addr == 3'd4 || hst_addr == 3'd5);
  wire wr_sts = hst_wr && hst_addr == 3'd6;

  assign push[0] = rx_push && !rx_resp && !full[0];
  assign push[1] = rx_push &&  rx_resp && !full[1];
  assign push[2] = wr_rq && !full[2];
  assign push[3] = wr_rp && !full[3];
  assign din[0]  = {rx_last, rx_data};
  assign din[1]  = {rx_last, rx_data};
  assign din[2]  = {hst_addr == 3'd3, hst_wdata};
  assign din[3]  = {hst_addr == 3'd5, hst_wdata};
  assign pop[0]  = rd_q0 && !empty[0];
  assign pop[1]  = rd_q1 && !empty[1];
  assign pop[2]  = tx_req_pop && pkts[0] != '0;
  assign pop[3]  = tx_rsp_pop && pkts[1] != '0;

  for (genvar g = 0; g < 4; g++) begin : g_q
    logic [DW:0]   mem [DEPTH];
    logic [AW-1:0] wp, rp;
    assign head[g]  = mem[rp];
    assign full[g]  = cnt[g] == FULLV;
    assign empty[g] = cnt[g] == '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0;
        rp <= '0;
        cnt[g] <= '0;
      end else begin
        if (push[g]) wp <= wp + 1'b1;
        if (pop[g])  rp <= rp + 1'b1;
        cnt[g] <= cnt[g] + (AW+1)'(push[g]) - (AW+1)'(pop[g]);
      end
    end
    always_ff @(posedge clk) if (push[g]) mem[wp] <= din[g];
  end

  for (genvar t = 0; t < 2; t++) begin : g_pk
    wire fin = push[t+2] && din[t+2][DW];
    wire gone = pop[t+2] && head[t+2][DW];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pkts[t] <= '0;
      else        pkts[t] <= pkts[t] + (AW+1)'(fin) - (AW+1)'(gone);
    end
  end

  wire [DW-1:0] sts = DW'({wr_err, rd_err, head[1][DW] & !empty[1], !empty[1],
                           head[0][DW] & !empty[0], !empty[0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_err    <= 1'b0;
      wr_err    <= 1'b0;
      hst_rdata <= '0;
    end else begin
      rd_err <= (rd_err && !(wr_sts && hst_wdata[4])) ||
                (rd_q0 && empty[0]) || (rd_q1 && empty[1]);
      wr_err <= (wr_err && !(wr_sts && hst_wdata[5])) ||
                (wr_rq && full[2]) || (wr_rp && full[3]);
      if (hst_rd) begin
        case (hst_addr)
          3'd0:    hst_rdata <= empty[0] ? '0 : head[0][DW-1:0];
          3'd1:    hst_rdata <= empty[1] ? '0 : head[1][DW-1:0];
          3'd6:    hst_rdata <= sts;
          default: hst_rdata <= '0;
        endcase
      end
    end
  end

  assign rx_req_full = full[0];
  assign rx_rsp_full = full[1];
  assign tx_req_data = head[2][DW-1:0];
  assign tx_req_end  = head[2][DW];
  assign tx_rsp_data = head[3][DW-1:0];
  assign tx_rsp_end  = head[3][DW];
  assign tx_req_pkts = pkts[0];
  assign tx_rsp_pkts = pkts[1];
endmodule

// File: rtl/host_async_queue_chk.sv
module host_async_queue_chk #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hst_rd,
  input logic                hst_wr,
  input logic [2:0]          hst_addr,
  input logic [DW-1:0]       hst_wdata,
  input logic                rx_push,
  input logic                rx_resp,
  input logic                tx_req_pop,
  input logic [$clog2(DEPTH):0]        tx_req_pkts,
  input logic [3:0][$clog2(DEPTH):0]   cnt,
  input logic                rd_err,
  input logic                wr_err
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);

  wire wr_full = hst_wr &&
    (((hst_addr == 3'd2 || hst_addr == 3'd3) && cnt[2] == FULLV) ||
     ((hst_addr == 3'd4 || hst_addr == 3'd5) && cnt[3] == FULLV));

  assert_rx_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && !rx_resp && cnt[0] != FULLV && !hst_rd |=> cnt[0] == $past(cnt[0]) + 1'b1);

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hst_rd && hst_addr == 3'd0 && cnt[0] == '0 && !(rx_push && !rx_resp)
    |=> rd_err && cnt[0] == '0);

  assert_ready_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hst_wr && hst_addr == 3'd3 && cnt[2] != FULLV && !tx_req_pop
    |=> tx_req_pkts == $past(tx_req_pkts) + 1'b1);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[2] <= FULLV && cnt[3] <= FULLV);

  assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hst_wr && hst_addr == 3'd2 && cnt[2] == FULLV && !tx_req_pop |=> cnt[2] == FULLV && wr_err);

  assert_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hst_wr && hst_addr == 3'd6 && hst_wdata[5] |=> !wr_err);
endmodule

bind host_async_queue host_async_queue_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_rd(hst_rd), .hst_wr(hst_wr),
  .hst_addr(hst_addr), .hst_wdata(hst_wdata), .rx_push(rx_push),
  .rx_resp(rx_resp), .tx_req_pop(tx_req_pop), .tx_req_pkts(tx_req_pkts),
  .cnt(cnt), .rd_err(rd_err), .wr_err(wr_err)
);

// File: tb/tb_host_async_queue.sv
module tb_host_async_queue;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic hst_rd = 0, hst_wr = 0;
  logic [2:0] hst_addr = 0;
  logic [DW-1:0] hst_wdata = 0, hst_rdata;
  logic rx_push = 0, rx_resp = 0, rx_last = 0;
  logic [DW-1:0] rx_data = 0;
  logic rx_req_full, rx_rsp_full;
  logic tx_req_pop = 0, tx_rsp_pop = 0;
  logic [DW-1:0] tx_req_data, tx_rsp_data;
  logic tx_req_end, tx_rsp_end;
  logic [3:0] tx_req_pkts, tx_rsp_pkts;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  host_async_queue #(.DW(DW), .DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_wr = 0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); hst_rd = 1; hst_addr = a;
    @(negedge clk); hst_rd = 0; d = hst_rdata;
  endtask

  task automatic rxput(input logic resp, input logic last, input logic [31:0] d);
    @(negedge clk); rx_push = 1; rx_resp = resp; rx_last = last; rx_data = d;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic txpop(input logic rsp);
    @(negedge clk); if (rsp) tx_rsp_pop = 1; else tx_req_pop = 1;
    @(negedge clk); tx_rsp_pop = 0; tx_req_pop = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    hread(3'd6, d);
    chk("R1 status", d, 0);
    chk("R1 req pkts", 32'(tx_req_pkts), 0);
    chk("R1 rsp pkts", 32'(tx_rsp_pkts), 0);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    rxput(0, 0, 32'hA0A0_0001);
    rxput(0, 0, 32'hA0A0_0002);
    rxput(0, 1, 32'hA0A0_0003);
    rxput(1, 0, 32'hB0B0_0001);
    rxput(1, 1, 32'hB0B0_0002);
    hread(3'd6, d);
    chk("R2 R3 both queues hold data, heads not final", d, 32'h5);
    hread(3'd0, d); chk("R4 req first", d, 32'hA0A0_0001);
    hread(3'd0, d); chk("R4 req second", d, 32'hA0A0_0002);
    hread(3'd6, d); chk("R5 req head final", d[1:0], 2'b11);
    hread(3'd0, d); chk("R4 req third", d, 32'hA0A0_0003);
    hread(3'd6, d); chk("R3 req drained", d[3:0], 4'b0100);
    hread(3'd1, d); chk("R2 rsp first", d, 32'hB0B0_0001);
    hread(3'd6, d); chk("R5 rsp head final", d[3:2], 2'b11);
    hread(3'd1, d); chk("R2 rsp second", d, 32'hB0B0_0002);
  endtask

  task automatic t_empty_read();
    logic [31:0] d;
    hread(3'd1, d); chk("R6 empty read data", d, 0);
    hread(3'd6, d); chk("R6 read error set", d, 32'h10);
    rxput(1, 1, 32'hC0C0_0001);
    hread(3'd1, d); chk("R6 no pop on empty", d, 32'hC0C0_0001);
    hwrite(3'd6, 32'h20);
    hread(3'd6, d); chk("R11 zero bit keeps flag", d, 32'h10);
    hwrite(3'd6, 32'h10);
    hread(3'd6, d); chk("R11 flag cleared", d, 0);
  endtask

  task automatic t_status_read();
    logic [31:0] d;
    rxput(0, 1, 32'hD0D0_0001);
    hread(3'd6, d);
    hread(3'd6, d); chk("R12 status read keeps data", d, 32'h3);
    hread(3'd0, d); chk("R12 quadlet intact", d, 32'hD0D0_0001);
  endtask

  task automatic t_tx();
    txpop(0);
    chk("R8 pop at zero ignored", 32'(tx_req_pkts), 0);
    hwrite(3'd2, 32'h1111_0001);
    hwrite(3'd2, 32'h1111_0002);
    chk("R8 no count before finish", 32'(tx_req_pkts), 0);
    hwrite(3'd3, 32'h1111_0003);
    chk("R8 finish counted", 32'(tx_req_pkts), 1);
    chk("R9 rsp untouched", 32'(tx_rsp_pkts), 0);
    chk("R7 head data", tx_req_data, 32'h1111_0001);
    chk("R7 head tag", 32'(tx_req_end), 0);
    txpop(0);
    chk("R7 second", tx_req_data, 32'h1111_0002);
    txpop(0);
    chk("R7 final data", tx_req_data, 32'h1111_0003);
    chk("R7 final tag", 32'(tx_req_end), 1);
    txpop(0);
    chk("R8 count back to 0", 32'(tx_req_pkts), 0);
    hwrite(3'd5, 32'h2222_0001);
    chk("R9 rsp count", 32'(tx_rsp_pkts), 1);
    chk("R9 req count", 32'(tx_req_pkts), 0);
    chk("R9 rsp head", tx_rsp_data, 32'h2222_0001);
    txpop(1);
    chk("R9 rsp drained", 32'(tx_rsp_pkts), 0);
  endtask

  task automatic t_full();
    logic [31:0] d;
    for (int i = 0; i < DEPTH - 1; i++) hwrite(3'd4, 32'h3300_0000 + 32'(i));
    hwrite(3'd5, 32'h33FF_FFFF);
    chk("R8 full packet counted", 32'(tx_rsp_pkts), 1);
    hwrite(3'd4, 32'hDEAD_BEEF);
    hread(3'd6, d); chk("R10 write error set", d, 32'h20);
    chk("R10 count unchanged", 32'(tx_rsp_pkts), 1);
    for (int i = 0; i < DEPTH - 1; i++) begin
      chk("R10 contents kept", tx_rsp_data, 32'h3300_0000 + 32'(i));
      txpop(1);
    end
    chk("R10 last entry", tx_rsp_data, 32'h33FF_FFFF);
    chk("R10 last tag", 32'(tx_rsp_end), 1);
    txpop(1);
    chk("R10 drained", 32'(tx_rsp_pkts), 0);
    hwrite(3'd6, 32'h30);
    hread(3'd6, d); chk("R11 write error cleared", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rx();
    t_empty_read();
    t_status_read();
    t_tx();
    t_full();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule